// File: doc/BRIEF.md
# Dual-Mode Finite-Field Multiply / Square-Multiply Array

This block is a purely combinational cellular array for arithmetic in GF(2^m), with elements held in polynomial basis. It takes two field elements, the low coefficients of a programmable reduction polynomial and a mode bit. It returns either the product of the two operands or the first operand times the square of the second. A square-multiply result in one pass is the step that exponentiation and inversion repeat. A controller can therefore build all of those on top of this one array.

The array is sized for a largest field degree `M`, with M columns of M cells each. The field degree `m` in use is a run-time input in the range 2..M. It picks which row of cells feeds the reduction carries to all the others. Every field size up to `M` therefore shares the same hardware. Each column folds in one bit of B. In product mode a column advances the running multiple of A by α. In square mode it advances it by α², using the reduced coefficients of α^(m+1) that the block derives from the polynomial itself. The block has no clock and no state, so its inputs and output are plain pins with no valid/ready handshake. The result is valid once the inputs have settled.

Top module: `gf_dual_mult`

## Requirements
- R1: With `sq_mode`=0, `prod` equals op_a·op_b reduced modulo x^m + Σ poly_low[i]·x^i, where bit i of every element is the coefficient of x^i.
- R2: With `sq_mode`=1, `prod` equals op_a·op_b·op_b reduced modulo the same polynomial.
- R3: Every field degree `field_m` from 2 to M gives the results of R1 and R2 for that degree, from the same array.
- R4: Bits at position `field_m` or above of `op_a`, `op_b` and `poly_low` have no effect on `prod`.
- R5: Bits of `prod` at position `field_m` or above are always 0.
- R6: If the masked op_a or op_b is zero, `prod` is 0. If the masked op_b is 1, `prod` equals the masked op_a, in both modes.
- R7: The reduction polynomial is taken from `poly_low` on every evaluation. Two polynomials of the same degree each give their own correct result with no reconfiguration.
- R8: `prod` depends only on the current inputs. A new input set gives its result with no clock edge and no history.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | M | Multiplicand A, bit i = coefficient of x^i |
| op_b | input | M | Operand B (squared in square mode) |
| poly_low | input | M | Reduction polynomial coefficients of x^0..x^(m-1) |
| field_m | input | $clog2(M+1) | Field degree m in use, 2..M |
| sq_mode | input | 1 | 0 = A·B, 1 = A·B² |
| prod | output | M | Result in GF(2^m), zero above bit m-1 |

## Verification
The hardest case to reach from the ports is a field degree below M. In that case the reduction carries must come from an inner row, and the unused upper rows and columns must stay inert even while junk sits in the upper operand and polynomial bits. The stimulus sweeps every degree from 2 to M with random polynomials and sets the ignored upper bits at random. It compares against a bit-serial shift-and-reduce reference, so carry selection and masking are both exercised. Both modes are checked exhaustively at degrees 4 and 8.

// File: rtl/gfa_pkg.sv
package gfa_pkg;
  typedef enum logic {
    GFA_PRODUCT = 1'b0,
    GFA_SQMUL   = 1'b1
  } gfa_mode_e;
endpackage

// File: rtl/gfa_field_prep.sv
module gfa_field_prep #(
  parameter int M  = 8,
  parameter int MW = $clog2(M + 1)
) (
  input  logic [M-1:0]  poly_low,
  input  logic [MW-1:0] field_m,
  input  logic          sq_mode,
  output logic [M-1:0]  f_used,
  output logic [M-1:0]  g_used,
  output logic [M-1:0]  row_sel,
  output logic [M-1:0]  row_keep
);
  logic f_top;

  for (genvar i = 0; i < M; i++) begin : g_rows
    assign row_sel[i]  = (field_m == MW'(i + 1));
    assign row_keep[i] = (MW'(i) < field_m);
  end

  assign f_used = poly_low & row_keep;
  assign f_top  = |(row_sel & f_used);

  // coefficients of alpha^(m+1), live only in square mode
  assign g_used[0] = sq_mode & f_top & f_used[0];
  for (genvar i = 1; i < M; i++) begin : g_alpha
    assign g_used[i] = sq_mode & row_keep[i] & ((f_top & f_used[i]) ^ f_used[i-1]);
  end

  always_comb begin
    if (field_m >= MW'(2) && field_m <= MW'(M))
      assert_row_sel_onehot_R3: assert ($countones(row_sel) == 1)
        else $error("row select not one-hot");
    if (!sq_mode)
      assert_alpha_terms_off_R1: assert (g_used == '0)
        else $error("square coefficients active in product mode");
  end
endmodule

// File: rtl/gfa_cell.sv
module gfa_cell (
  input  logic q_i,
  input  logic q_im1,
  input  logic q_im2,
  input  logic car_a,
  input  logic car_b,
  input  logic f_i,
  input  logic g_i,
  input  logic b_j,
  input  logic p_in,
  input  logic sq_mode,
  input  logic keep,
  output logic q_o,
  output logic p_o
);
  logic shifted;

  assign shifted = sq_mode ? q_im2 : q_im1;
  assign q_o     = keep & ((car_a & f_i) ^ (car_b & g_i) ^ shifted);
  assign p_o     = p_in ^ (q_i & b_j);
endmodule

// File: rtl/gfa_column.sv
module gfa_column #(
  parameter int M = 8
) (
  input  logic [M-1:0] q_in,
  input  logic [M-1:0] p_in,
  input  logic         b_j,
  input  logic [M-1:0] f_used,
  input  logic [M-1:0] g_used,
  input  logic [M-1:0] row_sel,
  input  logic [M-1:0] row_keep,
  input  logic         sq_mode,
  output logic [M-1:0] q_out,
  output logic [M-1:0] p_out
);
  logic top_q, next_q, car_a, car_b;

  assign top_q  = |(row_sel & q_in);
  assign next_q = |(row_sel & {q_in[M-2:0], 1'b0});
  assign car_a  = sq_mode ? next_q : top_q;
  assign car_b  = top_q;

  for (genvar i = 0; i < M; i++) begin : g_cell
    logic qm1, qm2;
    if (i >= 1) begin : g_m1
      assign qm1 = q_in[i-1];
    end else begin : g_m1z
      assign qm1 = 1'b0;
    end
    if (i >= 2) begin : g_m2
      assign qm2 = q_in[i-2];
    end else begin : g_m2z
      assign qm2 = 1'b0;
    end
    gfa_cell u_cell (
      .q_i    (q_in[i]),
      .q_im1  (qm1),
      .q_im2  (qm2),
      .car_a  (car_a),
      .car_b  (car_b),
      .f_i    (f_used[i]),
      .g_i    (g_used[i]),
      .b_j    (b_j),
      .p_in   (p_in[i]),
      .sq_mode(sq_mode),
      .keep   (row_keep[i]),
      .q_o    (q_out[i]),
      .p_o    (p_out[i])
    );
  end

  always_comb begin
    assert_q_stays_in_field_R5: assert ((q_out & ~row_keep) == '0)
      else $error("running multiple escaped field rows");
    if (!b_j)
      assert_idle_column_R4: assert (p_out == p_in)
        else $error("column with zero B bit changed the sum");
  end
endmodule

// File: rtl/gf_dual_mult.sv
module gf_dual_mult #(
  parameter int M  = 8,
  parameter int MW = $clog2(M + 1)
) (
  input  logic [M-1:0]  op_a,
  input  logic [M-1:0]  op_b,
  input  logic [M-1:0]  poly_low,
  input  logic [MW-1:0] field_m,
  input  logic          sq_mode,
  output logic [M-1:0]  prod
);
  import gfa_pkg::*;

  gfa_mode_e   mode;
  logic [M-1:0] f_used, g_used, row_sel, row_keep;
  logic [M-1:0] a_m, b_m;
  logic [M-1:0] q_ch [M+1];
  logic [M-1:0] p_ch [M+1];

  assign mode = gfa_mode_e'(sq_mode);

  gfa_field_prep #(.M(M), .MW(MW)) u_prep (
    .poly_low(poly_low),
    .field_m (field_m),
    .sq_mode (mode == GFA_SQMUL),
    .f_used  (f_used),
    .g_used  (g_used),
    .row_sel (row_sel),
    .row_keep(row_keep)
  );

  assign a_m     = op_a & row_keep;
  assign b_m     = op_b & row_keep;
  assign q_ch[0] = a_m;
  assign p_ch[0] = '0;

  for (genvar j = 0; j < M; j++) begin : g_col
    gfa_column #(.M(M)) u_col (
      .q_in    (q_ch[j]),
      .p_in    (p_ch[j]),
      .b_j     (b_m[j]),
      .f_used  (f_used),
      .g_used  (g_used),
      .row_sel (row_sel),
      .row_keep(row_keep),
      .sq_mode (mode == GFA_SQMUL),
      .q_out   (q_ch[j+1]),
      .p_out   (p_ch[j+1])
    );
  end

  assign prod = p_ch[M] & row_keep;

  always_comb begin
    assert_upper_result_zero_R5: assert ((prod & ~row_keep) == '0)
      else $error("result bit above field degree");
    if (a_m == '0 || b_m == '0)
      assert_zero_operand_R6: assert (prod == '0)
        else $error("zero operand gave nonzero result");
    if (b_m == M'(1))
      assert_unit_operand_R6: assert (prod == a_m)
        else $error("unit B did not return A");
  end
endmodule

// File: tb/test_gf_dual_mult.sv
module test_gf_dual_mult;
  localparam int M  = 8;
  localparam int MW = $clog2(M + 1);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [M-1:0]  op_a, op_b, poly_low, prod;
  logic [MW-1:0] field_m;
  logic          sq_mode;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  gf_dual_mult #(.M(M), .MW(MW)) i_gf_dual_mult (
    .op_a(op_a), .op_b(op_b), .poly_low(poly_low),
    .field_m(field_m), .sq_mode(sq_mode), .prod(prod)
  );

  function automatic logic [M-1:0] fmask(input int m);
    logic [M-1:0] r = '0;
    for (int i = 0; i < M; i++) if (i < m) r[i] = 1'b1;
    return r;
  endfunction

  // bit-serial shift-and-reduce, most significant B bit first
  function automatic logic [M-1:0] ref_mul(input logic [M-1:0] a, b, f, input int m);
    logic [M-1:0] msk = fmask(m);
    logic [M-1:0] r = '0;
    logic c;
    for (int i = M - 1; i >= 0; i--) begin
      if (i < m) begin
        c = r[m-1];
        r = (r << 1) & msk;
        if (c) r = r ^ (f & msk);
        if (b[i]) r = r ^ (a & msk);
      end
    end
    return r;
  endfunction

  function automatic logic [M-1:0] ref_res(input logic [M-1:0] a, b, f, input int m, input logic sq);
    if (sq) return ref_mul(a, ref_mul(b, b, f, m), f, m);
    return ref_mul(a, b, f, m);
  endfunction

  task automatic apply(input logic [M-1:0] a, b, f, input int m, input logic sq);
    @(posedge clk);
    op_a = a; op_b = b; poly_low = f; field_m = MW'(m); sq_mode = sq;
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [M-1:0] exp);
    checks++;
    if (prod !== exp) begin
      errors++;
      $display("FAIL %s: a=%h b=%h f=%h m=%0d sq=%0b got=%h exp=%h",
               tag, op_a, op_b, poly_low, field_m, sq_mode, prod, exp);
    end
  endtask

  task automatic run(input string tag, input logic [M-1:0] a, b, f, input int m, input logic sq);
    apply(a, b, f, m, sq);
    check(tag, ref_res(a, b, f, m, sq));
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    op_a = '0; op_b = '0; poly_low = '0; field_m = MW'(M); sq_mode = 1'b0;

    // R8: initial settled output with zero operands
    @(negedge clk);
    check("R8 initial", '0);

    // R6 directed corners
    run("R6 zero a",   8'h00, 8'h5A, 8'h1D, 8, 1'b0);
    run("R6 zero b",   8'h77, 8'h00, 8'h1D, 8, 1'b1);
    apply(8'hC3, 8'h01, 8'h1D, 8, 1'b1); check("R6 unit b sq", 8'hC3);
    apply(8'hC3, 8'h01, 8'h1D, 8, 1'b0); check("R6 unit b prod", 8'hC3);
    // x^7 * x in x^8+x^4+x^3+x^2+1 -> 0x1D
    apply(8'h80, 8'h02, 8'h1D, 8, 1'b0); check("R1 wrap", 8'h1D);
    // 1 * x^2 squared = x^4 in GF(16) x^4+x+1 -> x+1
    apply(4'h1, 4'h4, 4'h3, 4, 1'b1); check("R2 wrap", 8'h03);

    // R1 and R2 exhaustive at m=4
    for (int s = 0; s < 2; s++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          run(s ? "R2 m4" : "R1 m4", M'(a), M'(b), 8'h03, 4, s[0]);

    // R1 and R2 exhaustive at m=8 (R8: each result from a fresh input set)
    for (int s = 0; s < 2; s++)
      for (int a = 0; a < 256; a++)
        for (int b = 0; b < 256; b++)
          run(s ? "R2 m8" : "R1 m8", M'(a), M'(b), 8'h1D, 8, s[0]);

    // R7 two other polynomials of degree 8, same operands
    for (int k = 0; k < 300; k++) begin
      logic [M-1:0] a = M'($urandom), b = M'($urandom);
      logic s = 1'($urandom);
      run("R7 poly1B", a, b, 8'h1B, 8, s);
      run("R7 poly63", a, b, 8'h63, 8, s);
    end

    // R3 every degree with random polynomials; R4/R5 junk upper bits
    for (int k = 0; k < 1500; k++) begin
      int m = 2 + int'($urandom % (M - 1));
      logic [M-1:0] a = M'($urandom), b = M'($urandom), f = M'($urandom);
      logic s = 1'($urandom);
      logic [M-1:0] msk = fmask(m);
      apply(a, b, f, m, s);
      check("R3 sweep", ref_res(a & msk, b & msk, f & msk, m, s));
      checks++;
      if ((prod & ~msk) !== '0) begin
        errors++;
        $display("FAIL R5: upper bits got=%h exp=%h", prod & ~msk, M'(0));
      end
      // R4: same low bits, different upper junk, same result
      apply((a & msk) | (~msk & M'($urandom)), (b & msk) | (~msk & M'($urandom)),
            (f & msk) | (~msk & M'($urandom)), m, s);
      check("R4 ignore upper", ref_res(a & msk, b & msk, f & msk, m, s));
    end

    // R3 smallest field, exhaustive, poly x^2+x+1
    for (int s = 0; s < 2; s++)
      for (int a = 0; a < 4; a++)
        for (int b = 0; b < 4; b++)
          run("R3 m2", M'(a), M'(b), 8'h03, 2, s[0]);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: got=timeout exp=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule